// File: doc/BRIEF.md
# Clock Lane Gating Controller

This block decides, cycle by cycle, what the clock lane of a camera-serial transmitter is doing. In continuous mode the lane reaches high-speed once and keeps toggling. In non-continuous mode the lane goes back to the low-power stop state when no data lane needs it, but only while the video timing allows it. Which blanking intervals allow a release depends on a pixel-rate class input. At the low rate class only vertical blanking is used. At the high rate class a line gap can also be used, provided it is long enough.

The controller measures line blanking itself. It counts how long data-enable stays low between lines and compares that count against a fixed limit of 96 pixel clocks. The data lanes hold a request high while they need the clock. The controller drives the low-power and high-speed phases in order and raises a ready handshake once the clock has been toggling long enough. When the request drops, it keeps the clock running for a guard interval, then trails and exits before it will accept a new entry.

Top module: `clk_lane_gate`

## Requirements
- R1: While and after reset the lane code is LP-11 (code 0, where 1 is LP-01, 2 is LP-00 and 3 is high-speed), the clock enable is low and ready is low.
- R2: From LP-11, a request or continuous mode starts entry. The lane then shows LP-01 (code 1) for T_REQ cycles, LP-00 (code 2) for T_PREP cycles and HS-0 (code 3, clock enable low) for T_ZERO cycles. After that it toggles (code 3, clock enable high).
- R3: Ready rises only after T_PRE toggling cycles, so it is first high in the (T_PRE+1)-th toggling cycle. It is never high unless the clock enable is high.
- R4: The lane never stops toggling while the request is high. After the request drops, toggling continues for at least T_POST cycles.
- R5: On release the lane shows HS-0 (code 3, enable low) for T_TRAIL cycles, then LP-11 for T_EXIT cycles plus one stop cycle. Only after that can LP-01 appear, even if a request arrives during the exit.
- R6: In continuous mode (cont_mode_i high) the lane enters without a request. Once toggling, it keeps toggling regardless of request, blanking or rate class.
- R7: In non-continuous mode at the low rate class (hi_rate_i low), the lane is released only during vertical blanking. Vertical blanking runs from a vsync_i pulse until the next rising edge of de_i. Any line gap keeps the lane toggling.
- R8: At the high rate class the lane is also released in a line gap, with de_i low, if the de_i-low run that ended at the start of the current line lasted more than 96 cycles. A run of exactly 96 cycles keeps the lane toggling.
- R9: The first line after reset and the first line after each vsync_i pulse are treated as having a short gap before them, so the gap after that line does not release the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cont_mode_i | input | 1 | 1 selects continuous clock, 0 selects non-continuous |
| hi_rate_i | input | 1 | Pixel-rate class, 1 for high rate |
| vsync_i | input | 1 | Frame start pulse, marks vertical blanking |
| de_i | input | 1 | Data enable, high during active pixels of a line |
| clk_req_i | input | 1 | Data lanes need the high-speed clock |
| lane_state_o | output | 2 | Clock lane code: 0 LP-11, 1 LP-01, 2 LP-00, 3 high-speed |
| hs_clk_en_o | output | 1 | High-speed clock toggling (low during HS-0) |
| clk_ready_o | output | 1 | Clock ready handshake to the data lanes |

## Verification
The release decision and a fresh request can land in the same cycle, or a request can arrive while the lane is trailing or exiting. The request must win over a release, and the exit timer must win over a request. A directed case raises the request in the first exit cycle. Random lines then start their request at arbitrary points relative to the post-count expiry and to vsync. Every cycle the lane code, enable and ready are compared with a bench model built from the requirements.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

  typedef enum logic [1:0] {
    LANE_LP11 = 2'd0,
    LANE_LP01 = 2'd1,
    LANE_LP00 = 2'd2,
    LANE_HS   = 2'd3
  } lane_code_e;

  typedef enum logic [2:0] {
    PH_STOP,
    PH_REQ,
    PH_PREP,
    PH_ZERO,
    PH_HS,
    PH_TRAIL,
    PH_EXIT
  } phase_e;

  function automatic lane_code_e lane_code(phase_e p);
    unique case (p)
      PH_REQ:                    return LANE_LP01;
      PH_PREP:                   return LANE_LP00;
      PH_ZERO, PH_HS, PH_TRAIL:  return LANE_HS;
      default:                   return LANE_LP11;
    endcase
  endfunction

  function automatic phase_e phase_succ(phase_e p);
    unique case (p)
      PH_REQ:   return PH_PREP;
      PH_PREP:  return PH_ZERO;
      PH_ZERO:  return PH_HS;
      PH_TRAIL: return PH_EXIT;
      default:  return PH_STOP;
    endcase
  endfunction

endpackage

// File: rtl/clg_blank_meter.sv
module clg_blank_meter #(
  parameter int unsigned HBLANK_MIN = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic de_i,
  output logic long_o,
  output logic vblank_o
);
  localparam int unsigned SAT = HBLANK_MIN + 1;
  localparam int unsigned BW  = $clog2(SAT + 1);

  logic [BW-1:0] run_q;
  logic          de_q, long_q, vblank_q;
  logic          de_rise;

  assign de_rise  = de_i & ~de_q;
  assign long_o   = long_q;
  assign vblank_o = vblank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      de_q     <= 1'b0;
      long_q   <= 1'b0;
      vblank_q <= 1'b1;
    end else begin
      de_q <= de_i;
      if (de_i)                   run_q <= '0;
      else if (run_q != BW'(SAT)) run_q <= run_q + 1'b1;
      if (vsync_i) begin
        vblank_q <= 1'b1;
        long_q   <= 1'b0;
      end else if (de_rise) begin
        // first line of a frame always counts as short gap
        long_q   <= ~vblank_q & (run_q > BW'(HBLANK_MIN));
        vblank_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clg_hs_hold.sv
module clg_hs_hold #(
  parameter int unsigned T_PRE  = 2,
  parameter int unsigned T_POST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_hs_i,
  input  logic req_i,
  output logic ready_o,
  output logic post_done_o
);
  generate
    if (T_PRE == 0) begin : g_pre_none
      assign ready_o = in_hs_i;
    end else begin : g_pre_cnt
      localparam int unsigned PW = $clog2(T_PRE + 1);
      logic [PW-1:0] age_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      age_q <= '0;
        else if (!in_hs_i)                age_q <= '0;
        else if (age_q != PW'(T_PRE))     age_q <= age_q + 1'b1;
      end
      assign ready_o = in_hs_i & (age_q == PW'(T_PRE));
    end

    if (T_POST == 0) begin : g_post_none
      assign post_done_o = ~req_i;
    end else begin : g_post_cnt
      localparam int unsigned QW = $clog2(T_POST + 1);
      logic [QW-1:0] post_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      post_q <= '0;
        else if (!in_hs_i || req_i)       post_q <= '0;
        else if (post_q != QW'(T_POST))   post_q <= post_q + 1'b1;
      end
      assign post_done_o = (post_q == QW'(T_POST));
    end
  endgenerate
endmodule

// File: rtl/clg_lane_fsm.sv
module clg_lane_fsm
  import clk_gate_pkg::*;
#(
  parameter int unsigned T_REQ   = 2,
  parameter int unsigned T_PREP  = 3,
  parameter int unsigned T_ZERO  = 4,
  parameter int unsigned T_TRAIL = 3,
  parameter int unsigned T_EXIT  = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   release_i,
  output phase_e phase_o
);
  localparam int unsigned M1    = (T_REQ > T_PREP) ? T_REQ : T_PREP;
  localparam int unsigned M2    = (T_ZERO > T_TRAIL) ? T_ZERO : T_TRAIL;
  localparam int unsigned M3    = (M1 > M2) ? M1 : M2;
  localparam int unsigned T_MAX = (M3 > T_EXIT) ? M3 : T_EXIT;
  localparam int unsigned CW    = $clog2(T_MAX + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [CW-1:0] last_cycle(phase_e p);
    unique case (p)
      PH_REQ:   return CW'(T_REQ - 1);
      PH_PREP:  return CW'(T_PREP - 1);
      PH_ZERO:  return CW'(T_ZERO - 1);
      PH_TRAIL: return CW'(T_TRAIL - 1);
      PH_EXIT:  return CW'(T_EXIT - 1);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    unique case (ph_q)
      PH_STOP: begin
        cnt_d = '0;
        if (start_i) ph_d = PH_REQ;
      end
      PH_HS: begin
        cnt_d = '0;
        if (release_i) ph_d = PH_TRAIL;
      end
      default: begin
        if (cnt_q == last_cycle(ph_q)) begin
          cnt_d = '0;
          ph_d  = phase_succ(ph_q);
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_STOP;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/clk_lane_gate.sv
module clk_lane_gate
  import clk_gate_pkg::*;
#(
  parameter int unsigned T_REQ      = 2,
  parameter int unsigned T_PREP     = 3,
  parameter int unsigned T_ZERO     = 4,
  parameter int unsigned T_TRAIL    = 3,
  parameter int unsigned T_EXIT     = 4,
  parameter int unsigned T_PRE      = 2,
  parameter int unsigned T_POST     = 2,
  parameter int unsigned HBLANK_MIN = 96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cont_mode_i,
  input  logic       hi_rate_i,
  input  logic       vsync_i,
  input  logic       de_i,
  input  logic       clk_req_i,
  output logic [1:0] lane_state_o,
  output logic       hs_clk_en_o,
  output logic       clk_ready_o
);
  phase_e phase;
  logic   in_hs, in_vblank, line_long, post_done, ready;
  logic   start, release_ok, gap_ok;

  clg_blank_meter #(.HBLANK_MIN(HBLANK_MIN)) u_meter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vsync_i (vsync_i),
    .de_i    (de_i),
    .long_o  (line_long),
    .vblank_o(in_vblank)
  );

  clg_hs_hold #(.T_PRE(T_PRE), .T_POST(T_POST)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_hs_i    (in_hs),
    .req_i      (clk_req_i),
    .ready_o    (ready),
    .post_done_o(post_done)
  );

  clg_lane_fsm #(
    .T_REQ(T_REQ), .T_PREP(T_PREP), .T_ZERO(T_ZERO),
    .T_TRAIL(T_TRAIL), .T_EXIT(T_EXIT)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .release_i(release_ok),
    .phase_o  (phase)
  );

  assign in_hs      = (phase == PH_HS);
  assign start      = cont_mode_i | clk_req_i;
  // low rate: frame gaps only; high rate: also long line gaps
  assign gap_ok     = in_vblank | (hi_rate_i & line_long & ~de_i);
  assign release_ok = ~cont_mode_i & ~clk_req_i & post_done & gap_ok;

  assign lane_state_o = lane_code(phase);
  assign hs_clk_en_o  = in_hs;
  assign clk_ready_o  = ready;
endmodule

// File: rtl/clk_lane_gate_chk.sv
module clk_lane_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cont_mode_i,
  input logic       hi_rate_i,
  input logic       clk_req_i,
  input logic [1:0] lane_state_o,
  input logic       hs_clk_en_o,
  input logic       clk_ready_o,
  input logic       in_vblank_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_ready_needs_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ready_o |-> hs_clk_en_o);

  p_lp11_exit_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(lane_state_o) == 2'd0 && lane_state_o != 2'd0) |-> lane_state_o == 2'd1);

  p_lp01_exit_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(lane_state_o) == 2'd1 && lane_state_o != 2'd1) |-> lane_state_o == 2'd2);

  p_lp00_exit_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(lane_state_o) == 2'd2 && lane_state_o != 2'd2) |-> lane_state_o == 2'd3);

  p_stop_only_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(hs_clk_en_o)) |-> (!$past(clk_req_i) && !$past(cont_mode_i)));

  p_trail_hs0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(hs_clk_en_o)) |-> lane_state_o == 2'd3);

  p_cont_keeps_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(cont_mode_i) && $past(hs_clk_en_o)) |-> hs_clk_en_o);

  p_low_rate_frame_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(hs_clk_en_o) && !$past(hi_rate_i)) |-> $past(in_vblank_i));
endmodule

bind clk_lane_gate clk_lane_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cont_mode_i (cont_mode_i),
  .hi_rate_i   (hi_rate_i),
  .clk_req_i   (clk_req_i),
  .lane_state_o(lane_state_o),
  .hs_clk_en_o (hs_clk_en_o),
  .clk_ready_o (clk_ready_o),
  .in_vblank_i (in_vblank)
);

// File: tb/clk_lane_gate_test.sv
module clk_lane_gate_test;
  localparam int PERIOD  = 10;
  localparam int T_REQ   = 2;
  localparam int T_PREP  = 3;
  localparam int T_ZERO  = 4;
  localparam int T_TRAIL = 3;
  localparam int T_EXIT  = 4;
  localparam int T_PRE   = 2;
  localparam int T_POST  = 2;
  localparam int HB      = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cont = 1'b0, hi = 1'b0, vsync = 1'b0, de = 1'b0, req = 1'b0;
  logic [1:0] lane_state;
  logic hs_clk_en, clk_ready;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  clk_lane_gate #(
    .T_REQ(T_REQ), .T_PREP(T_PREP), .T_ZERO(T_ZERO), .T_TRAIL(T_TRAIL),
    .T_EXIT(T_EXIT), .T_PRE(T_PRE), .T_POST(T_POST), .HBLANK_MIN(HB)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .cont_mode_i(cont), .hi_rate_i(hi),
    .vsync_i(vsync), .de_i(de), .clk_req_i(req),
    .lane_state_o(lane_state), .hs_clk_en_o(hs_clk_en), .clk_ready_o(clk_ready)
  );

  // reference model: 0 stop,1 req,2 prep,3 zero,4 hs,5 trail,6 exit
  int m_ph, m_left, m_age, m_post, m_run;
  bit m_long, m_vbl, m_deq;

  function automatic int ph_len(int p);
    case (p)
      1: return T_REQ;
      2: return T_PREP;
      3: return T_ZERO;
      5: return T_TRAIL;
      6: return T_EXIT;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_code(int p);
    if (p == 1) return 1;
    if (p == 2) return 2;
    if (p >= 3 && p <= 5) return 3;
    return 0;
  endfunction

  wire m_rel = !cont && !req && (m_post >= T_POST) && (m_vbl || (hi && m_long && !de));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_age <= 0; m_post <= 0; m_run <= 0;
      m_long <= 0; m_vbl <= 1; m_deq <= 0;
    end else begin
      case (m_ph)
        0: if (cont || req) begin m_ph <= 1; m_left <= T_REQ - 1; end
        4: if (m_rel) begin m_ph <= 5; m_left <= T_TRAIL - 1; end
        default: begin
          if (m_left == 0) begin
            int nx;
            nx = (m_ph == 6) ? 0 : m_ph + 1;
            m_ph <= nx;
            m_left <= ph_len(nx) - 1;
          end else m_left <= m_left - 1;
        end
      endcase
      m_age  <= (m_ph == 4) ? ((m_age < T_PRE) ? m_age + 1 : T_PRE) : 0;
      m_post <= (m_ph == 4 && !req) ? ((m_post < T_POST) ? m_post + 1 : T_POST) : 0;
      m_run  <= de ? 0 : ((m_run < HB + 1) ? m_run + 1 : HB + 1);
      m_deq  <= de;
      if (vsync) begin m_vbl <= 1; m_long <= 0; end
      else if (de && !m_deq) begin m_long <= !m_vbl && (m_run > HB); m_vbl <= 0; end
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      int e, a;
      string tag;
      e = {exp_code(m_ph), (m_ph == 4), (m_ph == 4 && m_age >= T_PRE)};
      a = {lane_state, hs_clk_en, clk_ready};
      if (m_ph >= 1 && m_ph <= 3) tag = "R2 entry";
      else if (m_ph == 4) tag = (clk_ready != (m_age >= T_PRE)) ? "R3 ready" : "R4 hold";
      else tag = "R5 exit";
      check(tag, a == e, a, e);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1; de = 0; req = 0;
    @(negedge clk); vsync = 0;
  endtask

  task automatic run_line(input int act, input int blank, input int tail, output bit saw_off);
    saw_off = 0;
    for (int i = 0; i < act; i++) begin @(negedge clk); de = 1; req = 1; end
    for (int i = 0; i < blank; i++) begin
      @(negedge clk);
      if (i > 0 && !hs_clk_en) saw_off = 1;
      de = 0; req = (i < tail);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    bit off;
    void'($urandom(32'h1bad5eed));
    cyc(3);
    check("R1 reset code", lane_state == 0, lane_state, 0);
    check("R1 reset clk", hs_clk_en == 0, hs_clk_en, 0);
    check("R1 reset ready", clk_ready == 0, clk_ready, 0);
    rst_n = 1;
    cmp_en = 1;
    cyc(2);
    check("R1 idle after reset", lane_state == 0, lane_state, 0);

    // R2/R3: directed entry
    @(negedge clk); req = 1;
    for (int i = 0; i < T_REQ; i++) begin @(negedge clk); check("R2 LP-01", lane_state == 1, lane_state, 1); end
    for (int i = 0; i < T_PREP; i++) begin @(negedge clk); check("R2 LP-00", lane_state == 2, lane_state, 2); end
    for (int i = 0; i < T_ZERO; i++) begin
      @(negedge clk); check("R2 HS-0", {lane_state, hs_clk_en} == 3'b110, {lane_state, hs_clk_en}, 6);
    end
    for (int k = 1; k <= T_PRE + 1; k++) begin
      @(negedge clk);
      check("R2 toggling", hs_clk_en == 1, hs_clk_en, 1);
      check("R3 ready timing", clk_ready == (k == T_PRE + 1), clk_ready, (k == T_PRE + 1));
    end
    cyc(5);
    // R4/R5: release in frame gap, re-request during exit
    @(negedge clk); req = 0;
    for (int i = 0; i < T_POST; i++) begin @(negedge clk); check("R4 post hold", hs_clk_en == 1, hs_clk_en, 1); end
    for (int i = 0; i < T_TRAIL; i++) begin
      @(negedge clk); check("R5 trail", {lane_state, hs_clk_en, clk_ready} == 4'b1100,
                            {lane_state, hs_clk_en, clk_ready}, 12);
    end
    @(negedge clk); check("R5 exit LP-11", lane_state == 0, lane_state, 0); req = 1;
    for (int i = 0; i < T_EXIT; i++) begin @(negedge clk); check("R5 exit wait", lane_state == 0, lane_state, 0); end
    @(negedge clk); check("R5 re-entry", lane_state == 1, lane_state, 1);
    cyc(20);

    // R7: low rate keeps clock in line gaps, frees in frame gap
    hi = 0;
    run_line(20, 200, 3, off); check("R7 line gap 1", off == 0, off, 0);
    run_line(20, 200, 3, off); check("R7 line gap 2", off == 0, off, 0);
    vs_pulse(); cyc(4);
    check("R7 frame gap release", hs_clk_en == 0, hs_clk_en, 0);
    cyc(150);

    // R8/R9: high rate, measured gaps
    hi = 1;
    run_line(20, 97, 3, off);  check("R9 first line short", off == 0, off, 0);
    run_line(20, 96, 3, off);  check("R8 prior gap 97 frees", off == 1, off, 1);
    run_line(20, 150, 3, off); check("R8 prior gap 96 holds", off == 0, off, 0);
    run_line(20, 100, 3, off); check("R8 prior gap 150 frees", off == 1, off, 1);

    // R6: continuous mode
    cont = 1; cyc(30);
    check("R6 enters without request", hs_clk_en == 1, hs_clk_en, 1);
    vs_pulse(); cyc(40);
    check("R6 frame gap ignored", hs_clk_en == 1, hs_clk_en, 1);
    run_line(20, 200, 0, off); run_line(20, 200, 0, off);
    check("R6 line gaps ignored", off == 0, off, 0);
    cont = 0;

    // random frames
    for (int f = 0; f < 25; f++) begin
      int nl;
      hi = 1'($urandom % 2);
      cont = ($urandom % 8) == 0;
      vs_pulse();
      cyc(20 + $urandom % 150);
      nl = 2 + $urandom % 4;
      for (int l = 0; l < nl; l++) begin
        int b;
        case ($urandom % 4)
          0: b = 96;
          1: b = 97;
          2: b = 20 + $urandom % 180;
          default: b = 40 + $urandom % 60;
        endcase
        run_line(5 + $urandom % 30, b, $urandom % 6, off);
      end
    end
    cont = 0;
    cyc(50);
    summary();
    $finish;
  end
endmodule